// File: doc/BRIEF.md
# Integer Arithmetic Logic Unit

This block is the integer execute unit of a small scalar core. It has no clock. It takes two 32-bit operands and a 4-bit operation code, and it returns one 32-bit result in the same cycle. The operations are:

- wrapping add and subtract
- bitwise xor, or and and
- the three shift kinds
- signed less-than compare
- low and high halves of the product, the high half in signed and unsigned form
- a pass-through of the second operand

The block has no flags and no carry output. Overflow is dropped.

The decode stage places a register value on `opnd_a` and a register value or an immediate on `opnd_b`. It picks the operation with `op_sel`. The result is then written back. The operation map is sparse: codes 3, 10 and 14 have no operation and give a defined zero.

Top module: `int_alu`

## Requirements
- R1: When `op_sel` is 0, `result` is `opnd_a + opnd_b` modulo 2^32. The carry out is discarded.
- R2: When `op_sel` is 12, `result` is `opnd_a - opnd_b` modulo 2^32.
- R3: When `op_sel` is 4, 6 or 7, `result` is the bitwise xor, or, or and of the two operands, in that order.
- R4: When `op_sel` is 2, `result` is 1 if `opnd_a` is less than `opnd_b` as two's-complement integers, and 0 otherwise. Bits 31 to 1 are always zero.
- R5: For `op_sel` 1 (left, zero fill), 5 (right, zero fill) and 13 (right, sign fill), `opnd_a` is shifted by `opnd_b[4:0]`. Bits 31 to 5 of `opnd_b` have no effect on the result.
- R6: When `op_sel` is 8, `result` is bits [31:0] of the product of the operands.
- R7: When `op_sel` is 9, `result` is bits [63:32] of the 64-bit product with both operands treated as signed.
- R8: When `op_sel` is 11, `result` is bits [63:32] of the 64-bit product with both operands treated as unsigned.
- R9: When `op_sel` is 15, `result` equals `opnd_b`.
- R10: When `op_sel` is 3, 10 or 14, `result` is 0.
- R11: `result` depends only on the present inputs. It settles within the same cycle and holds no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand; the value that is shifted |
| opnd_b | input | 32 | Second operand; its low 5 bits give the shift amount |
| op_sel | input | 4 | Operation code |
| result | output | 32 | Result of the selected operation |

## Verification
Each of the 16 codes is driven with every pair drawn from a set of edge values: 0, 1, all-ones, the most negative value, the most positive value and 31.

- These pairs separate signed from unsigned treatment. For example, all-ones times all-ones has a high word of 0 when signed and 0xFFFFFFFE when unsigned. The pairs also separate wrap from saturation, and sign fill from zero fill.
- Shift amounts of 0 and 31 probe both ends of the shifter.
- A second shift pass sets bits 31 to 5 of the amount operand. If the result changes, a shifter is reading beyond the low five bits.
- Seeded random operands, mixed across all codes, cover products and comparisons whose high and low halves interact in ways no hand-picked value reaches.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

  localparam int unsigned OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 4'd0,
    OP_SLL   = 4'd1,
    OP_SLT   = 4'd2,
    OP_XOR   = 4'd4,
    OP_SRL   = 4'd5,
    OP_OR    = 4'd6,
    OP_AND   = 4'd7,
    OP_MULLO = 4'd8,
    OP_MULHS = 4'd9,
    OP_MULHU = 4'd11,
    OP_SUB   = 4'd12,
    OP_SRA   = 4'd13,
    OP_PASSB = 4'd15
  } alu_op_e;

endpackage

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             lt_signed
);

  logic [WIDTH:0]   full_unused;
  logic [WIDTH-1:0] b_eff;

  assign b_eff       = b ^ {WIDTH{sub}};
  assign full_unused = {1'b0, a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, sub};
  assign sum         = full_unused[WIDTH-1:0];

  // Valid when sub is set: differing signs decide directly, else the difference sign.
  assign lt_signed = (a[WIDTH-1] ^ b[WIDTH-1]) ? a[WIDTH-1] : sum[WIDTH-1];

endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned SH_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] a,
  input  logic [SH_W-1:0]  shamt,
  input  logic             left,
  input  logic             arith,
  output logic [WIDTH-1:0] out
);

  logic [WIDTH-1:0]        rev_in;
  logic [WIDTH-1:0]        rev_out;
  logic [WIDTH-1:0]        src;
  logic [WIDTH-1:0]        right;
  logic                    fill;
  logic signed [WIDTH:0]   ext;
  logic signed [WIDTH:0]   shifted_unused;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_rev
      assign rev_in[i]  = a[WIDTH-1-i];
      assign rev_out[i] = right[WIDTH-1-i];
    end
  endgenerate

  assign src            = left ? rev_in : a;
  assign fill           = arith & ~left & a[WIDTH-1];
  assign ext            = {fill, src};
  assign shifted_unused = ext >>> shamt;
  assign right          = shifted_unused[WIDTH-1:0];
  assign out            = left ? rev_out : right;

endmodule

// File: rtl/int_alu_mul.sv
module int_alu_mul #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sgn,
  input  logic             high,
  output logic [WIDTH-1:0] out
);

  logic signed [WIDTH:0]     ea;
  logic signed [WIDTH:0]     eb;
  logic signed [2*WIDTH+1:0] prod_unused;

  assign ea          = {sgn & a[WIDTH-1], a};
  assign eb          = {sgn & b[WIDTH-1], b};
  assign prod_unused = ea * eb;
  assign out         = high ? prod_unused[2*WIDTH-1:WIDTH] : prod_unused[WIDTH-1:0];

endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned SH_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [OP_W-1:0]  op_sel,
  output logic [WIDTH-1:0] result
);

  logic             do_sub;
  logic [WIDTH-1:0] as_sum;
  logic             as_lt;
  logic             sh_left;
  logic             sh_arith;
  logic [WIDTH-1:0] sh_out;
  logic             mul_sgn;
  logic             mul_high;
  logic [WIDTH-1:0] mul_out;

  assign do_sub   = (op_sel == OP_SUB) || (op_sel == OP_SLT);
  assign sh_left  = (op_sel == OP_SLL);
  assign sh_arith = (op_sel == OP_SRA);
  assign mul_sgn  = (op_sel == OP_MULHS);
  assign mul_high = (op_sel == OP_MULHS) || (op_sel == OP_MULHU);

  int_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a(opnd_a), .b(opnd_b), .sub(do_sub), .sum(as_sum), .lt_signed(as_lt)
  );

  int_alu_shift #(.WIDTH(WIDTH)) u_shift (
    .a(opnd_a), .shamt(opnd_b[SH_W-1:0]), .left(sh_left), .arith(sh_arith), .out(sh_out)
  );

  int_alu_mul #(.WIDTH(WIDTH)) u_mul (
    .a(opnd_a), .b(opnd_b), .sgn(mul_sgn), .high(mul_high), .out(mul_out)
  );

  always_comb begin
    case (op_sel)
      OP_ADD, OP_SUB:              result = as_sum;
      OP_SLT:                      result = {{(WIDTH-1){1'b0}}, as_lt};
      OP_SLL, OP_SRL, OP_SRA:      result = sh_out;
      OP_XOR:                      result = opnd_a ^ opnd_b;
      OP_OR:                       result = opnd_a | opnd_b;
      OP_AND:                      result = opnd_a & opnd_b;
      OP_MULLO, OP_MULHS, OP_MULHU: result = mul_out;
      OP_PASSB:                    result = opnd_b;
      default:                     result = '0;
    endcase
  end

endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk
  import int_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned SH_W = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [OP_W-1:0]  op_sel,
  input logic [WIDTH-1:0] result
);

  logic is_shift;
  logic is_hole;

  assign is_shift = (op_sel == OP_SLL) || (op_sel == OP_SRL) || (op_sel == OP_SRA);
  assign is_hole  = (op_sel == 4'd3) || (op_sel == 4'd10) || (op_sel == 4'd14);

  always_comb begin
    if (op_sel == OP_ADD) begin
      AST_ADD_WRAP: assert (result == opnd_a + opnd_b); // R1
    end
    if (op_sel == OP_SUB) begin
      AST_SUB_WRAP: assert (result + opnd_b == opnd_a); // R2
    end
    if (op_sel == OP_AND) begin
      AST_AND_SUBSET: assert ((result & ~opnd_a) == '0 && (result & ~opnd_b) == '0); // R3
    end
    if (op_sel == OP_SLT) begin
      AST_SLT_ONE_BIT: assert (result[WIDTH-1:1] == '0 && result[0] == ($signed(opnd_a) < $signed(opnd_b))); // R4
    end
    if (is_shift && opnd_b[SH_W-1:0] == '0) begin
      AST_SHIFT_BY_ZERO: assert (result == opnd_a); // R5
    end
    if (op_sel == OP_PASSB) begin
      AST_PASS_B: assert (result == opnd_b); // R9
    end
    if (is_hole) begin
      AST_HOLE_ZERO: assert (result == '0); // R10
    end
  end

endmodule

bind int_alu int_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel), .result(result)
);

// File: tb/int_alu_test.sv
module int_alu_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] a = '0;
  logic [31:0] b = '0;
  logic [3:0]  op = '0;
  logic [31:0] res;
  int          n_run = 0;
  int          n_fail = 0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  int_alu uut (.opnd_a(a), .opnd_b(b), .op_sel(op), .result(res));

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0: return "R1";
      4'd12: return "R2";
      4'd4, 4'd6, 4'd7: return "R3";
      4'd2: return "R4";
      4'd1, 4'd5, 4'd13: return "R5";
      4'd8: return "R6";
      4'd9: return "R7";
      4'd11: return "R8";
      4'd15: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [31:0] model(input logic [31:0] x, input logic [31:0] y,
                                        input logic [3:0] o);
    logic signed [63:0] ps;
    logic [63:0]        pu;
    ps = $signed({{32{x[31]}}, x}) * $signed({{32{y[31]}}, y});
    pu = {32'd0, x} * {32'd0, y};
    case (o)
      4'd0:  return x + y;
      4'd1:  return x << y[4:0];
      4'd2:  return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
      4'd4:  return x ^ y;
      4'd5:  return x >> y[4:0];
      4'd6:  return x | y;
      4'd7:  return x & y;
      4'd8:  return pu[31:0];
      4'd9:  return ps[63:32];
      4'd11: return pu[63:32];
      4'd12: return x - y;
      4'd13: return $signed(x) >>> y[4:0];
      4'd15: return y;
      default: return 32'd0;
    endcase
  endfunction

  task automatic apply(input logic [31:0] x, input logic [31:0] y, input logic [3:0] o,
                       input string tag);
    logic [31:0] exp;
    @(negedge clk);
    a = x; b = y; op = o;
    #2;
    exp = model(x, y, o);
    n_run++;
    if (res !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h", tag, o, x, y, res, exp);
    end
  endtask

  initial begin
    logic [31:0] corner [6];
    corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001; corner[2] = 32'hFFFF_FFFF;
    corner[3] = 32'h8000_0000; corner[4] = 32'h7FFF_FFFF; corner[5] = 32'd31;
    void'($urandom(32'h1234_5678));
    repeat (4) @(posedge clk);
    rst = 1'b0;
    // Reset state: zero inputs give zero result (R1, R11)
    @(negedge clk); #2;
    n_run++;
    if (res !== 32'd0) begin
      n_fail++; $display("FAIL R11 idle actual=%h expected=%h", res, 32'd0);
    end
    // Directed corner pairs for every code
    for (int o = 0; o < 16; o++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          apply(corner[i], corner[j], 4'(o), tag_of(4'(o)));
    // R5: upper bits of the shift amount are ignored, amounts 0 and 31 included
    for (int s = 0; s < 32; s++) begin
      apply(32'hA5C3_0F81, 32'hFFFF_FFE0 | 32'(s), 4'd1, "R5");
      apply(32'h8421_F00D, 32'h5555_5540 | 32'(s), 4'd5, "R5");
      apply(32'h9000_00F3, 32'h8000_0000 | 32'(s), 4'd13, "R5");
    end
    // R7/R8 distinct high words
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd9, "R7");
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd11, "R8");
    // R11: back-to-back changes settle within one cycle
    apply(32'd5, 32'd7, 4'd0, "R11");
    apply(32'd5, 32'd7, 4'd12, "R11");
    // Random operands across all codes
    for (int k = 0; k < 3200; k++)
      begin
        logic [3:0] ro;
        ro = 4'($urandom_range(0, 15));
        apply($urandom, $urandom, ro, tag_of(ro));
      end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule